// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the device side of an asynchronous-strobe dynamic memory interface. It samples the row strobe, column strobe, write enable, output enable, the 9-bit multiplexed address and the 4-bit write data on a fast system clock. From the order in which the strobe edges arrive, it decides which kind of memory cycle is in progress. It then issues one-cycle internal commands to a storage array: a read request with row and column, a write pulse with row, column and data, and a refresh pulse with the row to refresh. All strobes are active low, so 0 means asserted.

The row for a refresh comes from one of two places. A refresh driven by the row strobe alone uses the row on the address pins. A refresh started with the column strobe already low, including a hidden refresh behind a held read, uses an internal wrapping row counter. While the array is being read, the block drives the array's read data out under control of the column strobe and the output enable.

The controller has eight states. IDLE means the row strobe is high. ROW_OPEN means a row is open and no column has been taken yet. READ, EARLY_WR and LATE_WR are column accesses. PAGE means the column strobe is high again after an access in the open row. HIDDEN means read data is being held. CBR means the counter-refresh row is open. The transitions are as follows:
- IDLE goes to CBR on a row fall with the column strobe low, and to ROW_OPEN on a row fall with the column strobe high.
- ROW_OPEN and PAGE go to READ or EARLY_WR on a column fall, chosen by write enable. They go to IDLE on a row rise, and ROW_OPEN emits a pin-row refresh when it does.
- READ goes to LATE_WR on a write-enable fall, to PAGE on a column rise, and to HIDDEN on a row rise.
- EARLY_WR and LATE_WR go to PAGE on a column rise and to IDLE on a row rise.
- HIDDEN refreshes the counter row on each row fall. It leaves on a column rise, to IDLE if the row strobe is high and to CBR if it is low.
- CBR returns to IDLE on a row rise.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, rd_req, wr_pulse, rfsh_valid and dout_en are 0, and the first counter-sourced refresh uses row 0.
- R2: The row is taken from addr_in in the sample where row_stb_n falls, and the column in the sample where col_stb_n falls. Later changes on addr_in do not alter an access already issued.
- R3: A column fall with wr_en_n high issues a one-cycle rd_req carrying the latched row and column. It is visible on the second rising clock edge after the input change.
- R4: dout_en is 1 only during a read (including a held hidden-refresh read) while both col_stb_n and out_en_n are 0. It drops two edges after either one rises, and it returns if out_en_n falls again.
- R5: If wr_en_n is 0 when col_stb_n falls (early write), a one-cycle wr_pulse carries the row, the column and din from that sample, and dout_en stays 0 whatever out_en_n does.
- R6: If wr_en_n falls while col_stb_n is low in a read, a one-cycle wr_pulse carries the latched row and column and the din sampled at that wr_en_n fall.
- R7: A row fall and rise with no column fall in between gives one rfsh_valid pulse with rfsh_row equal to the latched pin row. wr_en_n and out_en_n have no effect on this, and no write is issued.
- R8: A row fall with col_stb_n already 0 gives one rfsh_valid pulse with the counter row. addr_in, wr_en_n and out_en_n are ignored: no rd_req, no wr_pulse, and dout_en stays 0.
- R9: The refresh counter advances by one after each counter-sourced refresh only, and wraps from 511 to 0.
- R10: With col_stb_n held low after a read, a row rise and a new row fall give a counter-sourced refresh, and dout_en stays 1 throughout.
- R11: While row_stb_n stays low, each new col_stb_n fall starts a new access in the same row with the new column (page mode).
- R12: A row rise after a column access has completed with col_stb_n high issues no refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr_in | input | AW (9) | Multiplexed row/column address |
| din | input | DW (4) | Write data from the pins |
| arr_rdata | input | DW (4) | Array read data for rd_row/rd_col |
| rd_req | output | 1 | One-cycle read request |
| rd_row | output | AW | Row of the latest read |
| rd_col | output | AW | Column of the latest read |
| wr_pulse | output | 1 | One-cycle write strobe |
| wr_row | output | AW | Write row |
| wr_col | output | AW | Write column |
| wr_data | output | DW | Write data |
| rfsh_valid | output | 1 | One-cycle refresh pulse |
| rfsh_row | output | AW | Row to refresh |
| dout | output | DW | Read data toward the pins |
| dout_en | output | 1 | Output drive enable |

## Verification
Each input passes through one sampling register and then one output register. So every pulse, latched field and dout_en change is due on the second rising edge after the stimulus and lasts exactly one cycle where it is a pulse. The bench changes inputs just after a falling edge and reads results two falling edges later. A falling-edge monitor tallies each pulse exactly once with its fields. One read is probed cycle by cycle to confirm that nothing shows after one edge and that the pulse is gone after three.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_OPEN,
        ST_READ,
        ST_EARLY_WR,
        ST_LATE_WR,
        ST_PAGE,
        ST_HIDDEN,
        ST_CBR
    } cyc_state_e;
endpackage

// File: rtl/dcd_sampler.sv
module dcd_sampler #(
    parameter int AW = 9,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_stb_n,
    input  logic          col_stb_n,
    input  logic          wr_en_n,
    input  logic          out_en_n,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] din,
    output logic          s_ras_n,
    output logic          s_cas_n,
    output logic          s_we_n,
    output logic          s_oe_n,
    output logic [AW-1:0] s_addr,
    output logic [DW-1:0] s_din,
    output logic          ras_fall,
    output logic          ras_rise,
    output logic          cas_fall,
    output logic          cas_rise,
    output logic          we_fall
);
    logic p_ras_n, p_cas_n, p_we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_ras_n <= 1'b1;
            s_cas_n <= 1'b1;
            s_we_n  <= 1'b1;
            s_oe_n  <= 1'b1;
            s_addr  <= '0;
            s_din   <= '0;
            p_ras_n <= 1'b1;
            p_cas_n <= 1'b1;
            p_we_n  <= 1'b1;
        end else begin
            s_ras_n <= row_stb_n;
            s_cas_n <= col_stb_n;
            s_we_n  <= wr_en_n;
            s_oe_n  <= out_en_n;
            s_addr  <= addr_in;
            s_din   <= din;
            p_ras_n <= s_ras_n;
            p_cas_n <= s_cas_n;
            p_we_n  <= s_we_n;
        end
    end

    assign ras_fall = p_ras_n & ~s_ras_n;
    assign ras_rise = ~p_ras_n & s_ras_n;
    assign cas_fall = p_cas_n & ~s_cas_n;
    assign cas_rise = ~p_cas_n & s_cas_n;
    assign we_fall  = p_we_n & ~s_we_n;
endmodule

// File: rtl/dcd_rfsh_ctr.sv
module dcd_rfsh_ctr #(
    parameter int ROW_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    output logic [ROW_BITS-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   row <= '0;
        else if (adv) row <= row + 1'b1;
    end

    // R9: one step per counter refresh, modulo the row count
    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv) |-> row == ROW_BITS'($past(row) + 1'b1));
    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(adv) |-> $stable(row));
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_stb_n,
    input  logic          col_stb_n,
    input  logic          wr_en_n,
    input  logic          out_en_n,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] arr_rdata,
    output logic          rd_req,
    output logic [AW-1:0] rd_row,
    output logic [AW-1:0] rd_col,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_row,
    output logic [AW-1:0] wr_col,
    output logic [DW-1:0] wr_data,
    output logic          rfsh_valid,
    output logic [AW-1:0] rfsh_row,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    logic          s_ras_n, s_cas_n, s_we_n, s_oe_n;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_din;
    logic          ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic [AW-1:0] cnt_row;

    cyc_state_e    st, nxt;
    logic [AW-1:0] row_q, col_q;
    logic          ld_row, ld_col, fire_rd, fire_wr, fire_rf_pin, fire_rf_cnt;

    dcd_sampler #(.AW(AW), .DW(DW)) u_smp (
        .clk(clk), .rst_n(rst_n),
        .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
        .wr_en_n(wr_en_n), .out_en_n(out_en_n),
        .addr_in(addr_in), .din(din),
        .s_ras_n(s_ras_n), .s_cas_n(s_cas_n), .s_we_n(s_we_n), .s_oe_n(s_oe_n),
        .s_addr(s_addr), .s_din(s_din),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall)
    );

    dcd_rfsh_ctr #(.ROW_BITS(AW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .adv(fire_rf_cnt), .row(cnt_row)
    );

    // Cycle classification from strobe edge order
    always_comb begin
        nxt         = st;
        ld_row      = 1'b0;
        ld_col      = 1'b0;
        fire_rd     = 1'b0;
        fire_wr     = 1'b0;
        fire_rf_pin = 1'b0;
        fire_rf_cnt = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (!s_cas_n) begin
                        fire_rf_cnt = 1'b1;
                        nxt         = ST_CBR;
                    end else begin
                        ld_row = 1'b1;
                        nxt    = ST_ROW_OPEN;
                    end
                end
            end
            ST_ROW_OPEN, ST_PAGE: begin
                if (ras_rise) begin
                    fire_rf_pin = (st == ST_ROW_OPEN);
                    nxt         = ST_IDLE;
                end else if (cas_fall) begin
                    ld_col = 1'b1;
                    if (!s_we_n) begin
                        fire_wr = 1'b1;
                        nxt     = ST_EARLY_WR;
                    end else begin
                        fire_rd = 1'b1;
                        nxt     = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (ras_rise)      nxt = ST_HIDDEN;
                else if (cas_rise) nxt = ST_PAGE;
                else if (we_fall) begin
                    fire_wr = 1'b1;
                    nxt     = ST_LATE_WR;
                end
            end
            ST_EARLY_WR, ST_LATE_WR: begin
                if (ras_rise)      nxt = ST_IDLE;
                else if (cas_rise) nxt = ST_PAGE;
            end
            ST_HIDDEN: begin
                if (cas_rise)      nxt = s_ras_n ? ST_IDLE : ST_CBR;
                else if (ras_fall) fire_rf_cnt = 1'b1;
            end
            ST_CBR: begin
                if (ras_rise) nxt = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Registered outputs and address latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q      <= '0;
            col_q      <= '0;
            rd_req     <= 1'b0;
            rd_row     <= '0;
            rd_col     <= '0;
            wr_pulse   <= 1'b0;
            wr_row     <= '0;
            wr_col     <= '0;
            wr_data    <= '0;
            rfsh_valid <= 1'b0;
            rfsh_row   <= '0;
            dout_en    <= 1'b0;
        end else begin
            if (ld_row) row_q <= s_addr;
            if (ld_col) col_q <= s_addr;
            rd_req <= fire_rd;
            if (fire_rd) begin
                rd_row <= row_q;
                rd_col <= s_addr;
            end
            wr_pulse <= fire_wr;
            if (fire_wr) begin
                wr_row  <= row_q;
                wr_col  <= (st == ST_READ) ? col_q : s_addr;
                wr_data <= s_din;
            end
            rfsh_valid <= fire_rf_pin | fire_rf_cnt;
            if (fire_rf_pin)      rfsh_row <= row_q;
            else if (fire_rf_cnt) rfsh_row <= cnt_row;
            dout_en <= ((nxt == ST_READ) || (nxt == ST_HIDDEN) || (nxt == ST_LATE_WR))
                       && !s_cas_n && !s_oe_n;
        end
    end

    assign dout = dout_en ? arr_rdata : '0;

    // R8: refresh, write and read commands never coincide
    p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rfsh_valid, wr_pulse, rd_req}));
    // R3: a read request follows a column-low, write-high sample
    p_rd_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> $past(!s_cas_n && s_we_n));
    // R6: a write pulse follows a sample with write enable and column low
    p_wr_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(!s_we_n && !s_cas_n));
    // R4: drive only after a sample with column strobe and output enable low
    p_drive_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!s_cas_n && !s_oe_n));
endmodule

// File: tb/dram_cycle_decoder_bench.sv
`timescale 1ns/1ps
module dram_cycle_decoder_bench;
    localparam int AW = 9;
    localparam int DW = 4;
    localparam logic [2:0] OP_EW = 3'd0, OP_RD = 3'd1, OP_LW = 3'd2, OP_RO = 3'd3, OP_CB = 3'd4;

    typedef struct packed {
        logic [2:0]    op;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
        logic [DW-1:0] dat;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{OP_EW, 9'h101, 9'h002, 4'hA},
        '{OP_EW, 9'h0F2, 9'h1C1, 4'h5},
        '{OP_RD, 9'h101, 9'h002, 4'h0},
        '{OP_LW, 9'h0F2, 9'h1C1, 4'h3},
        '{OP_RD, 9'h0F2, 9'h1C1, 4'h0},
        '{OP_RO, 9'h155, 9'h000, 4'h0},
        '{OP_CB, 9'h000, 9'h000, 4'h0},
        '{OP_RD, 9'h101, 9'h002, 4'h0},
        '{OP_CB, 9'h000, 9'h000, 4'h0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_stb_n = 1'b1, col_stb_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] arr_rdata;
    logic          rd_req, wr_pulse, rfsh_valid, dout_en;
    logic [AW-1:0] rd_row, rd_col, wr_row, wr_col, rfsh_row;
    logic [DW-1:0] wr_data, dout;

    always #2 clk = ~clk;

    dram_cycle_decoder #(.AW(AW), .DW(DW)) u_dram_cycle_decoder (
        .clk(clk), .rst_n(rst_n),
        .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
        .wr_en_n(wr_en_n), .out_en_n(out_en_n),
        .addr_in(addr_in), .din(din), .arr_rdata(arr_rdata),
        .rd_req(rd_req), .rd_row(rd_row), .rd_col(rd_col),
        .wr_pulse(wr_pulse), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .rfsh_valid(rfsh_valid), .rfsh_row(rfsh_row),
        .dout(dout), .dout_en(dout_en)
    );

    // Array stub: 16 cells indexed by low row and column bits
    logic [DW-1:0] stub [16];
    logic [DW-1:0] ref_mem [16];
    initial for (int i = 0; i < 16; i++) begin stub[i] = '0; ref_mem[i] = '0; end
    always @(posedge clk) if (wr_pulse) stub[{wr_row[1:0], wr_col[1:0]}] <= wr_data;
    assign arr_rdata = stub[{rd_row[1:0], rd_col[1:0]}];

    // Pulse monitor
    int n_rd = 0, n_wr = 0, n_rf = 0;
    logic [AW-1:0] lr_row, lr_col, lw_row, lw_col, lf_row;
    logic [DW-1:0] lw_dat;
    always @(negedge clk) begin
        if (rd_req)     begin n_rd++; lr_row = rd_row; lr_col = rd_col; end
        if (wr_pulse)   begin n_wr++; lw_row = wr_row; lw_col = wr_col; lw_dat = wr_data; end
        if (rfsh_valid) begin n_rf++; lf_row = rfsh_row; end
    end

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [AW-1:0] exp_cnt = '0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    function automatic int ix(input logic [AW-1:0] r, input logic [AW-1:0] c);
        return int'({r[1:0], c[1:0]});
    endfunction

    task automatic t_ewrite(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic [DW-1:0] d);
        int nw = n_wr;
        addr_in = r; row_stb_n = 0; tk(2);
        addr_in = c; din = d; wr_en_n = 0; out_en_n = 0; col_stb_n = 0;
        tk(1); chk("R5 no drive", dout_en, 0);
        tk(1); chk("R5 no drive", dout_en, 0);
        chk("R5 wr count", n_wr, nw + 1);
        chk("R5 wr row", lw_row, r); chk("R5 wr col", lw_col, c); chk("R5 wr data", lw_dat, d);
        col_stb_n = 1; wr_en_n = 1; out_en_n = 1; tk(2);
        row_stb_n = 1; tk(2);
        ref_mem[ix(r, c)] = d;
    endtask

    task automatic t_lwrite(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic [DW-1:0] d);
        int nw = n_wr; int nr = n_rd;
        addr_in = r; row_stb_n = 0; tk(2);
        addr_in = c; din = ~d; col_stb_n = 0; tk(2);
        chk("R3 read before late write", n_rd, nr + 1);
        din = d; wr_en_n = 0; addr_in = '0; tk(2);
        chk("R6 wr count", n_wr, nw + 1);
        chk("R6 wr row", lw_row, r); chk("R6 wr col", lw_col, c); chk("R6 wr data", lw_dat, d);
        col_stb_n = 1; wr_en_n = 1; tk(2);
        row_stb_n = 1; tk(2);
        ref_mem[ix(r, c)] = d;
    endtask

    task automatic t_read(input logic [AW-1:0] r, input logic [AW-1:0] c);
        int nr = n_rd;
        addr_in = r; row_stb_n = 0; tk(2);
        addr_in = c; out_en_n = 0; col_stb_n = 0; tk(2);
        chk("R3 rd count", n_rd, nr + 1);
        chk("R2 rd row", lr_row, r); chk("R2 rd col", lr_col, c);
        chk("R4 drive", dout_en, 1);
        chk("R3 rd data", dout, ref_mem[ix(r, c)]);
        col_stb_n = 1; out_en_n = 1; tk(2);
        chk("R4 release", dout_en, 0);
        row_stb_n = 1; tk(2);
    endtask

    task automatic t_rasonly(input logic [AW-1:0] r);
        int nf = n_rf; int nw = n_wr;
        addr_in = r; wr_en_n = 0; out_en_n = 0; row_stb_n = 0; tk(2);
        addr_in = ~r; row_stb_n = 1; tk(2);
        chk("R7 rf count", n_rf, nf + 1); chk("R7 rf row", lf_row, r);
        chk("R7 no write", n_wr, nw); chk("R7 no drive", dout_en, 0);
        wr_en_n = 1; out_en_n = 1; tk(1);
    endtask

    task automatic t_cbr();
        int nf = n_rf; int nw = n_wr; int nr = n_rd;
        col_stb_n = 0; wr_en_n = 0; out_en_n = 0; addr_in = 9'h1AA; tk(1);
        row_stb_n = 0; tk(2);
        chk("R8 rf count", n_rf, nf + 1); chk("R9 counter row", lf_row, exp_cnt);
        chk("R8 no write", n_wr, nw); chk("R8 no read", n_rd, nr); chk("R8 no drive", dout_en, 0);
        row_stb_n = 1; tk(1);
        col_stb_n = 1; wr_en_n = 1; out_en_n = 1; tk(2);
        exp_cnt = exp_cnt + 1'b1;
    endtask

    initial begin
        vec_t v;
        int nf, nr;
        tk(3);
        chk("R1 rd_req", rd_req, 0); chk("R1 wr_pulse", wr_pulse, 0);
        chk("R1 rfsh_valid", rfsh_valid, 0); chk("R1 dout_en", dout_en, 0);
        rst_n = 1; tk(2);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            case (v.op)
                OP_EW:   t_ewrite(v.row, v.col, v.dat);
                OP_RD:   t_read(v.row, v.col);
                OP_LW:   t_lwrite(v.row, v.col, v.dat);
                OP_RO:   t_rasonly(v.row);
                default: t_cbr();
            endcase
        end

        // R3 latency, R4 gating, R2 hold, R11 page, R12 no refresh
        nr = n_rd; nf = n_rf;
        addr_in = 9'h0F2; row_stb_n = 0; tk(2);
        addr_in = 9'h1C1; col_stb_n = 0; out_en_n = 0;
        tk(1); chk("R3 not yet", rd_req, 0);
        tk(1); chk("R3 due", rd_req, 1); chk("R4 drive", dout_en, 1);
        tk(1); chk("R3 one cycle", rd_req, 0);
        out_en_n = 1; tk(2); chk("R4 oe off", dout_en, 0);
        out_en_n = 0; tk(2); chk("R4 oe on", dout_en, 1);
        addr_in = 9'h000; tk(2);
        chk("R2 col held", lr_col, 9'h1C1); chk("R2 no new read", n_rd, nr + 1);
        col_stb_n = 1; tk(2); chk("R4 cas off", dout_en, 0);
        addr_in = 9'h002; col_stb_n = 0; tk(2);
        chk("R11 page count", n_rd, nr + 2);
        chk("R11 page row", lr_row, 9'h0F2); chk("R11 page col", lr_col, 9'h002);
        chk("R11 page data", dout, ref_mem[ix(9'h0F2, 9'h002)]);
        col_stb_n = 1; out_en_n = 1; tk(2);
        row_stb_n = 1; tk(2);
        chk("R12 no refresh", n_rf, nf);

        // R10 hidden refresh
        nf = n_rf;
        addr_in = 9'h101; row_stb_n = 0; tk(2);
        addr_in = 9'h002; out_en_n = 0; col_stb_n = 0; tk(2);
        chk("R10 read data", dout, ref_mem[ix(9'h101, 9'h002)]);
        row_stb_n = 1; tk(1); chk("R10 hold", dout_en, 1);
        tk(1); chk("R10 hold", dout_en, 1);
        row_stb_n = 0; tk(2);
        chk("R10 rf count", n_rf, nf + 1); chk("R10 rf row", lf_row, exp_cnt);
        chk("R10 hold", dout_en, 1);
        exp_cnt = exp_cnt + 1'b1;
        row_stb_n = 1; tk(2); chk("R10 hold", dout_en, 1);
        col_stb_n = 1; out_en_n = 1; tk(2); chk("R10 release", dout_en, 0);

        // R9 wrap of the refresh counter
        while (exp_cnt != 9'd511) t_cbr();
        t_cbr();
        chk("R9 last row", lf_row, 9'd511);
        t_cbr();
        chk("R9 wrap", lf_row, 9'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule